// File: doc/BRIEF.md
# Multi-Step Conversion Sequencer

This block runs a converter through a programmable list of conversion steps. Software fills in a per-step configuration word and a per-step settling delay through a word-addressed register port. It then writes a step-enable mask and sets the global enable. The sequencer visits the enabled steps in ascending order. For each step it waits the settling delay, measured in converter clock ticks from a prescaler, and then requests one or more samples over a request/acknowledge handshake. It averages the samples by a power-of-two count and pushes the tagged result into one of two result FIFOs.

Each FIFO has a count register, a programmable threshold and a read port whose data register pops one word per read. One write-one-to-clear status register collects the threshold, end-of-pass and overflow events. The `irq` output is the OR of its bits. A step run in one-shot mode drops out of the mask when it finishes, so software re-arms the mask for the next pass. Steps in continuous mode stay armed, and passes repeat for as long as such a step is enabled.

The controller has six states:

| State | Action |
|---|---|
| S_IDLE | Waits for work. |
| S_SCAN | Picks the next enabled step at or after the cursor. |
| S_OPEN | Counts settling ticks. |
| S_CONV | Holds the sample request and accumulates the acknowledged samples. |
| S_STORE | Pushes the result and advances the cursor. |
| S_DONE | Flags the end of a pass. |

The transitions are:

- IDLE→SCAN on enable with a nonzero mask.
- SCAN→SCAN for the charge step.
- SCAN→OPEN when a conversion step is found.
- SCAN→DONE when no enabled step is left.
- OPEN→CONV when the delay has elapsed.
- CONV→STORE on the last sample.
- STORE→SCAN.
- DONE→IDLE.
- Any state → IDLE when the global enable is cleared.

Top module: `adc_step_sequencer`

Register word addresses:

| Address | Register |
|---|---|
| 0x00 | Control. Bit 0 is the global enable. |
| 0x01 | Prescaler, holding the divide ratio minus one. |
| 0x02 | Step mask, bits 16:0. |
| 0x03 | Status. |
| 0x04, 0x05 | Thresholds for FIFO 0 and FIFO 1. |
| 0x06, 0x07 | Counts for FIFO 0 and FIFO 1. |
| 0x08, 0x09 | Data for FIFO 0 and FIFO 1. |
| 0x10+n-1 | Configuration of step n. |
| 0x20+n-1 | Settling delay of step n. |

Status bits:

| Bit | Event |
|---|---|
| 0 | FIFO 0 threshold |
| 1 | FIFO 1 threshold |
| 2 | End of pass |
| 3 | FIFO 0 overflow |
| 4 | FIFO 1 overflow |

## Requirements
- R1: After reset the status register, both FIFO counts and the step mask read 0, and `adc_req` is low.
- R2: Enabled conversion steps are converted in ascending step order within a pass. `adc_sel` carries bits 3:0 of the active step's configuration word and stays stable while `adc_req` is held.
- R3: Configuration bits 6:4 hold the averaging code. Codes 0, 1, 2, 3 and 4 take 1, 2, 4, 8 and 16 samples, and any larger code acts as 4. The stored result is the sample sum divided by the sample count, rounded down.
- R4: A FIFO word carries the 12-bit result in bits 11:0 and the number of the step that produced it in bits 20:16.
- R5: Configuration bit 7 routes a step's result to FIFO 1 when set and to FIFO 0 when clear.
- R6: A step with settling delay D waits D converter ticks before its first sample request. With D = 0 the request rises in the third cycle after the mask write.
- R7: The prescaler register holds the divide ratio minus one. While the block is enabled a converter tick occurs once every ratio clocks.
- R8: A FIFO's threshold status bit is set in every cycle in which its count exceeds its threshold register. Writing a one to the bit does not clear it while that condition holds.
- R9: Status bits clear when a one is written to them. Bit 2 is set once the last enabled step of a pass has completed.
- R10: A step whose configuration bit 8 is clear (one-shot) has its mask bit cleared on completion. A step with bit 8 set (continuous) keeps its mask bit, and passes then repeat.
- R11: Clearing control bit 0 stops the sequencer at once: `adc_req` goes low and no further results are pushed.
- R12: A read of a FIFO data address returns the oldest word and decrements that FIFO's count. A read of an empty FIFO returns 0 and leaves the count at 0.
- R13: Each FIFO holds 64 words. A push into a full FIFO is dropped and sets that FIFO's sticky overflow status bit.
- R14: Mask bit 0 selects the charge step. The charge step performs no conversion, pushes nothing and clears its own mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops when addressing a FIFO data register |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| adc_req | output | 1 | Sample request to the converter |
| adc_sel | output | 4 | Input selected for the requested sample |
| adc_ack | input | 1 | Converter acknowledge; `adc_data` is valid with it |
| adc_data | input | 12 | Converted sample |
| irq | output | 1 | OR of all status bits |

## Verification
The checker watches several properties on every cycle:

- `adc_req` is never high while the block is disabled.
- The selected input holds steady during a request.
- The end-of-pass bit follows every visit to the done state.
- No FIFO count exceeds its depth, and a count moves by at most one per cycle.

The directed scenarios are needed for the behaviour that depends on data and timing:

- the ascending order of steps across a sparse mask;
- the exact averaged values for each code;
- FIFO routing and the step tags in the FIFO words;
- settling-delay timing against the prescaler ratio;
- re-assertion of a threshold bit that is cleared while still above the threshold;
- the drop of the 65th result together with its overflow flag.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_OPEN,
        S_CONV,
        S_STORE,
        S_DONE
    } seq_state_t;

    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_PRESC = 8'h01;
    localparam logic [7:0] A_MASK  = 8'h02;
    localparam logic [7:0] A_STAT  = 8'h03;
    localparam logic [7:0] A_THR0  = 8'h04;
    localparam logic [7:0] A_THR1  = 8'h05;
    localparam logic [7:0] A_CNT0  = 8'h06;
    localparam logic [7:0] A_CNT1  = 8'h07;
    localparam logic [7:0] A_DATA0 = 8'h08;
    localparam logic [7:0] A_DATA1 = 8'h09;

    localparam logic [3:0] PAGE_CFG = 4'h1;
    localparam logic [3:0] PAGE_DLY = 4'h2;

    localparam int ST_THR0 = 0;
    localparam int ST_THR1 = 1;
    localparam int ST_EOS  = 2;
    localparam int ST_OVF0 = 3;
    localparam int ST_OVF1 = 4;
    localparam int ST_W    = 5;

endpackage

// File: rtl/adcseq_prescale.sv
module adcseq_prescale #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] ratio_m1,
    output logic         tick
);

    logic [W-1:0] cnt;

    assign tick = run && (cnt >= ratio_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/adcseq_fifo.sv
module adcseq_fifo #(
    parameter int WW    = 21,
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [WW-1:0] din,
    input  logic          pop,
    output logic [WW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          drop
);

    logic [WW-1:0] mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic          full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign dout    = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp    <= '0;
            wp    <= '0;
            count <= '0;
        end else begin
            if (do_push)
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/adc_step_sequencer.sv
module adc_step_sequencer
    import adcseq_pkg::*;
#(
    parameter int NSTEP = 16,
    parameter int DEPTH = 64,
    parameter int DW    = 12,
    parameter int PSW   = 16,
    parameter int DLYW  = 8,
    localparam int CSW  = $clog2(NSTEP + 2),
    localparam int SIW  = $clog2(NSTEP),
    localparam int CNTW = $clog2(DEPTH + 1),
    localparam int WW   = CSW + 4 + DW,
    localparam int AccW = DW + 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        adc_req,
    output logic [3:0]  adc_sel,
    input  logic        adc_ack,
    input  logic [11:0] adc_data,
    output logic        irq
);

    // programming state
    logic             glb_en;
    logic [PSW-1:0]   div_q;
    logic [NSTEP:0]   mask;
    logic [CNTW-1:0]  thr0, thr1, cnt0, cnt1;
    logic [ST_W-1:0]  status;
    logic [8:0]       cfg_q [NSTEP];
    logic [DLYW-1:0]  dly_q [NSTEP];

    // sequencer state
    seq_state_t       state, state_nx;
    logic [CSW-1:0]   cur, nxt_idx;
    logic             found;
    logic [DLYW-1:0]  dly_cnt;
    logic [AccW-1:0]  acc;
    logic [4:0]       smp;
    logic             tick;

    logic [CSW-1:0]   sidx;
    logic [8:0]       cur_cfg;
    logic [DLYW-1:0]  cur_dly;
    logic [2:0]       eff;
    logic [4:0]       smp_last;
    logic [DW-1:0]    result;
    logic             push0, push1, drop0, drop1, clr_en;
    logic [CSW-1:0]   clr_idx;
    logic [WW-1:0]    word, dout0, dout1;

    assign sidx     = cur - 1'b1;
    assign cur_cfg  = cfg_q[sidx[SIW-1:0]];
    assign cur_dly  = dly_q[sidx[SIW-1:0]];
    assign eff      = (cur_cfg[6:4] > 3'd4) ? 3'd4 : cur_cfg[6:4];
    assign smp_last = (5'd1 << eff) - 5'd1;
    assign result   = DW'(acc >> eff);
    assign word     = {cur, 4'b0000, result};
    assign irq      = |status;

    adcseq_prescale #(.W(PSW)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(glb_en), .ratio_m1(div_q), .tick(tick)
    );

    adcseq_fifo #(.WW(WW), .DEPTH(DEPTH)) u_fifo0 (
        .clk(clk), .rst_n(rst_n), .push(push0), .din(word),
        .pop(reg_rd && reg_addr == A_DATA0), .dout(dout0), .count(cnt0), .drop(drop0)
    );

    adcseq_fifo #(.WW(WW), .DEPTH(DEPTH)) u_fifo1 (
        .clk(clk), .rst_n(rst_n), .push(push1), .din(word),
        .pop(reg_rd && reg_addr == A_DATA1), .dout(dout1), .count(cnt1), .drop(drop1)
    );

    // per-step configuration storage
    for (genvar s = 0; s < NSTEP; s++) begin : g_step
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[s] <= '0;
                dly_q[s] <= '0;
            end else if (reg_wr) begin
                if (reg_addr == {PAGE_CFG, 4'(s)}) cfg_q[s] <= reg_wdata[8:0];
                if (reg_addr == {PAGE_DLY, 4'(s)}) dly_q[s] <= reg_wdata[DLYW-1:0];
            end
        end
    end

    // global registers, mask and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_en <= 1'b0;
            div_q  <= '0;
            mask   <= '0;
            thr0   <= '0;
            thr1   <= '0;
            status <= '0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL)  glb_en <= reg_wdata[0];
            if (reg_wr && reg_addr == A_PRESC) div_q  <= reg_wdata[PSW-1:0];
            if (reg_wr && reg_addr == A_THR0)  thr0   <= reg_wdata[CNTW-1:0];
            if (reg_wr && reg_addr == A_THR1)  thr1   <= reg_wdata[CNTW-1:0];
            if (reg_wr && reg_addr == A_MASK)  mask   <= reg_wdata[NSTEP:0];
            else if (clr_en)                   mask[clr_idx] <= 1'b0;
            status <= (status & ~((reg_wr && reg_addr == A_STAT) ? reg_wdata[ST_W-1:0] : '0))
                    | {drop1, drop0, state == S_DONE, cnt1 > thr1, cnt0 > thr0};
        end
    end

    // lowest enabled step at or after the cursor
    always_comb begin
        found   = 1'b0;
        nxt_idx = '0;
        for (int i = NSTEP; i >= 0; i--) begin
            if (mask[i] && CSW'(i) >= cur) begin
                found   = 1'b1;
                nxt_idx = CSW'(i);
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (|mask) state_nx = S_SCAN;
            S_SCAN:  if (!found) state_nx = S_DONE;
                     else if (nxt_idx != '0) state_nx = S_OPEN;
            S_OPEN:  if (dly_cnt == cur_dly) state_nx = S_CONV;
            S_CONV:  if (adc_ack && smp == smp_last) state_nx = S_STORE;
            S_STORE: state_nx = S_SCAN;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
        if (!glb_en) state_nx = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // step datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= '0;
            dly_cnt <= '0;
            acc     <= '0;
            smp     <= '0;
        end else begin
            unique case (state)
                S_IDLE:  cur <= '0;
                S_SCAN:  if (found) begin
                             cur     <= (nxt_idx == '0) ? CSW'(1) : nxt_idx;
                             dly_cnt <= '0;
                             acc     <= '0;
                             smp     <= '0;
                         end
                S_OPEN:  if (tick && dly_cnt != cur_dly) dly_cnt <= dly_cnt + 1'b1;
                S_CONV:  if (adc_ack) begin
                             acc <= acc + AccW'(adc_data);
                             smp <= smp + 1'b1;
                         end
                S_STORE: cur <= cur + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        adc_req = (state == S_CONV) && glb_en;
        adc_sel = cur_cfg[3:0];
        push0   = (state == S_STORE) && glb_en && !cur_cfg[7];
        push1   = (state == S_STORE) && glb_en &&  cur_cfg[7];
        clr_en  = 1'b0;
        clr_idx = cur;
        if (state == S_SCAN && found && nxt_idx == '0) begin
            clr_en  = 1'b1;
            clr_idx = '0;
        end else if (state == S_STORE && glb_en && !cur_cfg[8]) begin
            clr_en  = 1'b1;
        end
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:  reg_rdata = 32'(glb_en);
            A_PRESC: reg_rdata = 32'(div_q);
            A_MASK:  reg_rdata = 32'(mask);
            A_STAT:  reg_rdata = 32'(status);
            A_THR0:  reg_rdata = 32'(thr0);
            A_THR1:  reg_rdata = 32'(thr1);
            A_CNT0:  reg_rdata = 32'(cnt0);
            A_CNT1:  reg_rdata = 32'(cnt1);
            A_DATA0: reg_rdata = 32'(dout0);
            A_DATA1: reg_rdata = 32'(dout1);
            default: begin
                if (reg_addr[7:4] == PAGE_CFG) reg_rdata = 32'(cfg_q[reg_addr[SIW-1:0]]);
                if (reg_addr[7:4] == PAGE_DLY) reg_rdata = 32'(dly_q[reg_addr[SIW-1:0]]);
            end
        endcase
    end

endmodule

// File: rtl/adc_step_sequencer_chk.sv
module adc_step_sequencer_chk
    import adcseq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNTW  = 7
) (
    input logic            clk,
    input logic            rst_n,
    input seq_state_t      state,
    input logic            glb_en,
    input logic            adc_req,
    input logic [3:0]      adc_sel,
    input logic [ST_W-1:0] status,
    input logic [CNTW-1:0] cnt0,
    input logic [CNTW-1:0] cnt1
);

    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req |-> glb_en); // R11

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && $past(adc_req)) |-> $stable(adc_sel)); // R2

    AST_EOS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) |=> status[ST_EOS]); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt0 <= CNTW'(DEPTH)) && (cnt1 <= CNTW'(DEPTH))); // R13

    AST_COUNT_STEP0: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt0 == $past(cnt0)) || (cnt0 == $past(cnt0) + 1'b1) || (cnt0 == $past(cnt0) - 1'b1)); // R12

    AST_COUNT_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt1 == $past(cnt1)) || (cnt1 == $past(cnt1) + 1'b1) || (cnt1 == $past(cnt1) - 1'b1)); // R12

endmodule

bind adc_step_sequencer adc_step_sequencer_chk #(.DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .glb_en(glb_en), .adc_req(adc_req),
    .adc_sel(adc_sel), .status(status), .cnt0(cnt0), .cnt1(cnt1)
);

// File: tb/adc_step_sequencer_tb.sv
`timescale 1ns/1ps
module adc_step_sequencer_tb;

    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        adc_req, adc_ack;
    logic [3:0]  adc_sel;
    logic [11:0] adc_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int sel_log [16];
    int sel_n = 0;
    int k_smp = 0;
    logic req_prev = 1'b0;

    always #(CLK_NS / 2.0) clk = ~clk;

    adc_step_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_req(adc_req), .adc_sel(adc_sel),
        .adc_ack(adc_ack), .adc_data(adc_data), .irq(irq)
    );

    // converter model: sample k of input s returns s*200 + 8*k
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_ack  <= 1'b0;
            adc_data <= '0;
            k_smp    <= 0;
        end else if (!adc_req) begin
            adc_ack <= 1'b0;
            k_smp   <= 0;
        end else if (!adc_ack) begin
            adc_ack  <= 1'b1;
            adc_data <= 12'(int'(adc_sel) * 200 + 8 * k_smp);
            k_smp    <= k_smp + 1;
        end else begin
            adc_ack <= 1'b0;
        end
    end

    // request monitor
    always @(negedge clk) begin
        if (adc_req && !req_prev && sel_n < 16) begin
            sel_log[sel_n] = int'(adc_sel);
            sel_n = sel_n + 1;
        end
        req_prev = adc_req;
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(CLK_NS * 150000.0);
        fails = fails + 1;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input bit pop, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = pop;
        #2 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic cfg_step(input int n, input int inp, input int avg, input int fsel,
                            input int cont, input int dly);
        wr(8'(8'h10 + n - 1), 32'((cont << 8) | (fsel << 7) | (avg << 4) | inp));
        wr(8'(8'h20 + n - 1), 32'(dly));
    endtask

    task automatic wait_eos();
        logic [31:0] d;
        for (int i = 0; i < 400; i++) begin
            rd(8'h03, 1'b0, d);
            if (d[2]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h03, 1'b0, d); check(d == 0, "R1 status", d, 0);
        rd(8'h06, 1'b0, d); check(d == 0, "R1 count0", d, 0);
        rd(8'h07, 1'b0, d); check(d == 0, "R1 count1", d, 0);
        rd(8'h02, 1'b0, d); check(d == 0, "R1 mask", d, 0);
        check(adc_req == 1'b0, "R1 adc_req", adc_req, 0);
    endtask

    task automatic t_order();
        logic [31:0] d;
        cfg_step(3, 5, 0, 0, 0, 0);
        cfg_step(7, 2, 0, 1, 0, 0);
        cfg_step(12, 9, 0, 0, 0, 0);
        wr(8'h03, 32'h1F);
        sel_n = 0;
        wr(8'h02, 32'h0000_1089);
        wait_eos();
        check(sel_n == 3, "R14 conversions", sel_n, 3);
        check(sel_log[0] == 5 && sel_log[1] == 2 && sel_log[2] == 9, "R2 order",
              sel_log[0] * 100 + sel_log[1] * 10 + sel_log[2], 529);
        rd(8'h02, 1'b0, d); check(d == 0, "R10 R14 mask cleared", d, 0);
        rd(8'h06, 1'b0, d); check(d == 2, "R5 count0", d, 2);
        rd(8'h07, 1'b0, d); check(d == 1, "R5 count1", d, 1);
        rd(8'h08, 1'b1, d);
        check(d[20:16] == 3 && d[11:0] == 1000, "R4 fifo0 first", d, (3 << 16) | 1000);
        rd(8'h06, 1'b0, d); check(d == 1, "R12 pop decrements", d, 1);
        rd(8'h08, 1'b1, d);
        check(d[20:16] == 12 && d[11:0] == 1800, "R4 fifo0 second", d, (12 << 16) | 1800);
        rd(8'h09, 1'b1, d);
        check(d[20:16] == 7 && d[11:0] == 400, "R5 fifo1 word", d, (7 << 16) | 400);
        rd(8'h08, 1'b1, d); check(d == 0, "R12 empty read", d, 0);
        rd(8'h06, 1'b0, d); check(d == 0, "R12 count stays 0", d, 0);
        rd(8'h03, 1'b0, d); check(d[2] == 1'b1, "R9 eos set", d[2], 1);
        wr(8'h03, 32'h4);
        rd(8'h03, 1'b0, d); check(d[2] == 1'b0, "R9 eos cleared", d[2], 0);
    endtask

    task automatic t_avg();
        logic [31:0] d;
        for (int code = 0; code < 6; code++) begin
            int n = 1 << ((code > 4) ? 4 : code);
            cfg_step(1, 4, code, 0, 0, 0);
            wr(8'h03, 32'h1F);
            wr(8'h02, 32'h2);
            wait_eos();
            rd(8'h08, 1'b1, d);
            check(d[11:0] == 12'(800 + 4 * (n - 1)), "R3 average", d[11:0], 800 + 4 * (n - 1));
        end
    endtask

    task automatic t_delay();
        logic [31:0] d;
        int n;
        wr(8'h01, 32'd4);
        cfg_step(2, 1, 0, 0, 0, 3);
        wr(8'h03, 32'h1F);
        wr(8'h02, 32'h4);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); n = n + 1; #1;
            if (adc_req) break;
        end
        check(n >= 14 && n <= 18, "R6 R7 delay 3 ratio 5", n, 16);
        wait_eos();
        rd(8'h08, 1'b1, d);
        cfg_step(2, 1, 0, 0, 0, 0);
        wr(8'h03, 32'h1F);
        wr(8'h02, 32'h4);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); n = n + 1; #1;
            if (adc_req) break;
        end
        check(n == 3, "R6 zero delay", n, 3);
        wait_eos();
        rd(8'h08, 1'b1, d);
        wr(8'h01, 32'd0);
    endtask

    task automatic t_thresh();
        logic [31:0] d;
        wr(8'h05, 32'd1);
        cfg_step(5, 3, 0, 1, 0, 0);
        wr(8'h03, 32'h1F);
        wr(8'h02, 32'h20);
        wait_eos();
        rd(8'h03, 1'b0, d); check(d[1] == 1'b0, "R8 below threshold", d[1], 0);
        wr(8'h03, 32'h1F);
        wr(8'h02, 32'h20);
        wait_eos();
        rd(8'h03, 1'b0, d); check(d[1] == 1'b1, "R8 above threshold", d[1], 1);
        wr(8'h03, 32'h2);
        rd(8'h03, 1'b0, d); check(d[1] == 1'b1, "R8 reasserts", d[1], 1);
        rd(8'h09, 1'b1, d);
        wr(8'h03, 32'h2);
        rd(8'h03, 1'b0, d); check(d[1] == 1'b0, "R8 R9 cleared", d[1], 0);
        rd(8'h09, 1'b1, d);
    endtask

    task automatic t_ovf();
        logic [31:0] d;
        wr(8'h04, 32'd63);
        cfg_step(1, 6, 0, 0, 1, 0);
        wr(8'h03, 32'h1F);
        wr(8'h02, 32'h2);
        for (int i = 0; i < 2000; i++) begin
            rd(8'h06, 1'b0, d);
            if (d == 64) break;
        end
        repeat (40) @(posedge clk);
        rd(8'h03, 1'b0, d);
        check(d[3] == 1'b1, "R13 overflow flag", d[3], 1);
        check(d[0] == 1'b1, "R8 fifo0 threshold", d[0], 1);
        wr(8'h00, 32'h0);
        check(adc_req == 1'b0, "R11 req dropped", adc_req, 0);
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1;
            if (adc_req) check(1'b0, "R11 req while disabled", 1, 0);
        end
        rd(8'h06, 1'b0, d); check(d == 64, "R13 count capped", d, 64);
        rd(8'h02, 1'b0, d); check(d[1] == 1'b1, "R10 continuous kept", d[1], 1);
        wr(8'h03, 32'h8);
        rd(8'h03, 1'b0, d); check(d[3] == 1'b0, "R13 R11 no new drop", d[3], 0);
        rd(8'h08, 1'b1, d);
        check(d[20:16] == 1 && d[11:0] == 1200, "R4 continuous word", d, (1 << 16) | 1200);
        for (int i = 0; i < 63; i++) rd(8'h08, 1'b1, d);
        rd(8'h06, 1'b0, d); check(d == 0, "R12 drained", d, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        wr(8'h01, 32'd0);
        wr(8'h00, 32'h1);
        t_order();
        t_avg();
        t_delay();
        t_thresh();
        t_ovf();
        summary();
        $finish;
    end

endmodule